// File: doc/BRIEF.md
# ADC Output Word Formatter

This block sits between a 12-bit converter core and its output serializer. Each cycle it takes a raw sample with two overrange flags and builds the word the serializer sends. The word has twelve data bits and two extra status bits. The data bits can be coded as offset binary or as two's complement. An optional scrambling step folds the least significant bit into every other data bit to spread digital interference across the spectrum. A programmable test pattern can replace the whole word for board-level interface checks.

Static control inputs select these options. They also select the serialization width (12, 14 or 16 bits), which decides whether the two status bits are carried. A disable input silences the data and the driver enable that the frame and clock outputs share. The package provides the receive-side descrambling function, so a capture path can recover the formatted code.

Every output is registered, with one cycle from input to output.

Top module: `adc_word_fmt`

## Requirements
- R1: With every option off, `word_out[11:0]` equals the sample one cycle later, coded as offset binary: 0x800 is mid-scale, 0xFFF is the top code and 0x000 is the bottom code.
- R2: With `cfg_twos` high, the data field is the offset-binary code with bit 11 inverted: mid-scale gives 0x000, the top code gives 0x7FF and the bottom code gives 0x800.
- R3: `ovr_pos` forces the top code of the selected coding (0xFFF or 0x7FF). Otherwise `ovr_neg` forces the bottom code (0x000 or 0x800). `ovr_pos` wins if both flags are high.
- R4: `word_out[13:12]` are the status bits. `cfg_ser_w` is coded 0 = 12-bit, 1 = 14-bit, 2 or 3 = 16-bit. In 14-bit and 16-bit modes both status bits are 1 on positive overrange and 0 otherwise, negative overrange included. In 12-bit mode both are always 0.
- R5: With `cfg_scramble` high, each of data bits 11..1 is XORed with data bit 0 after coding, and bit 0 is unchanged. The package function `xor_lsb` applied to the output data field gives back the coded value.
- R6: With `cfg_tp_en` high, the word is `cfg_tp_val`, and coding, clipping and scrambling have no effect. In 12-bit mode bits 13:12 of the word are still forced to 0.
- R7: With `cfg_out_off` high, the next cycle shows `word_out` = 0, `word_vld` = 0 and `drv_en` = 0. With it low, `drv_en` is 1 and is never changed by the scrambler.
- R8: `word_vld` is `smp_vld` delayed by one cycle while the output is enabled.
- R9: After synchronous reset, `word_out`, `word_vld` and `drv_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | 12 | Raw converter sample, offset binary |
| smp_vld | input | 1 | Sample valid |
| ovr_pos | input | 1 | Positive overrange flag |
| ovr_neg | input | 1 | Negative overrange flag |
| cfg_twos | input | 1 | Select two's complement coding |
| cfg_scramble | input | 1 | Enable the LSB-XOR scrambler |
| cfg_tp_en | input | 1 | Enable the test pattern override |
| cfg_tp_val | input | 14 | Test pattern word (status bits 13:12, data 11:0) |
| cfg_ser_w | input | 2 | Serialization width: 0=12, 1=14, 2/3=16 |
| cfg_out_off | input | 1 | Output disable |
| word_out | output | 14 | Formatted word: status bits 13:12, data 11:0 |
| word_vld | output | 1 | Word valid |
| drv_en | output | 1 | Output driver enable for data, frame and clock |

## Verification
A wrong coding or clipping stage would show up as a wrong data field in the very next cycle. The bench's reference model reaches the extremes of the code range in both codings and in both overrange directions. Wrong scrambler wiring would alter only the words whose bit 0 is set, so odd and even samples are both driven, with the option on and off. A priority fault between the test pattern and the other options would show at once as a non-pattern word. So would a status bit that leaks through in 12-bit mode, or a disable that fails to clear the word, valid and driver enable. Each of these cases is compared against the model one cycle after its stimulus.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  localparam int DATA_W = 12;
  localparam int EXT_W  = 2;

  typedef enum logic [1:0] {
    SER_W12  = 2'd0,
    SER_W14  = 2'd1,
    SER_W16  = 2'd2,
    SER_W16B = 2'd3
  } ser_width_e;

  // Scramble and descramble are the same operation: XOR bit 0 into every higher bit.
  function automatic logic [DATA_W-1:0] xor_lsb(input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] r;
    r = w;
    for (int i = 1; i < DATA_W; i++) r[i] = w[i] ^ w[0];
    return r;
  endfunction
endpackage

// File: rtl/adc_fmt_clip_conv.sv
module adc_fmt_clip_conv #(
  parameter int DW = 12
) (
  input  logic [DW-1:0] smp,
  input  logic          ovr_pos,
  input  logic          ovr_neg,
  input  logic          twos,
  output logic [DW-1:0] code
);
  localparam logic [DW-1:0] TOP = {DW{1'b1}};
  localparam logic [DW-1:0] BOT = {DW{1'b0}};

  logic [DW-1:0] clipped;

  // Positive overrange takes priority over negative.
  always_comb begin
    if (ovr_pos)      clipped = TOP;
    else if (ovr_neg) clipped = BOT;
    else              clipped = smp;
  end

  // Two's complement is offset binary with the sign bit flipped.
  always_comb begin
    code = clipped;
    if (twos) code[DW-1] = ~clipped[DW-1];
  end
endmodule

// File: rtl/adc_fmt_scramble.sv
module adc_fmt_scramble #(
  parameter int DW = 12
) (
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic key;
  assign key     = en & din[0];
  assign dout[0] = din[0];

  for (genvar i = 1; i < DW; i++) begin : g_bit
    assign dout[i] = din[i] ^ key;
  end
endmodule

// File: rtl/adc_fmt_out_stage.sv
module adc_fmt_out_stage #(
  parameter int DW = 12,
  parameter int XW = 2,
  localparam int OW = DW + XW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] data,
  input  logic [XW-1:0] ext,
  input  logic          ext_keep,
  input  logic          tp_en,
  input  logic [OW-1:0] tp_val,
  input  logic          off,
  input  logic          vld_in,
  output logic [OW-1:0] word_out,
  output logic          word_vld,
  output logic          drv_en
);
  logic [OW-1:0] sel;
  logic [OW-1:0] nxt;

  // The test pattern sits last in the chain, so it overrides every other option.
  always_comb begin
    sel = tp_en ? tp_val : {ext, data};
    nxt = sel;
    if (!ext_keep) nxt[OW-1:DW] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out <= '0;
      word_vld <= 1'b0;
      drv_en   <= 1'b0;
    end else if (off) begin
      word_out <= '0;
      word_vld <= 1'b0;
      drv_en   <= 1'b0;
    end else begin
      word_out <= nxt;
      word_vld <= vld_in;
      drv_en   <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_word_fmt.sv
module adc_word_fmt
  import adc_fmt_pkg::*;
#(
  parameter int DW = adc_fmt_pkg::DATA_W,
  parameter int XW = adc_fmt_pkg::EXT_W,
  localparam int OW = DW + XW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] smp_in,
  input  logic          smp_vld,
  input  logic          ovr_pos,
  input  logic          ovr_neg,
  input  logic          cfg_twos,
  input  logic          cfg_scramble,
  input  logic          cfg_tp_en,
  input  logic [OW-1:0] cfg_tp_val,
  input  logic [1:0]    cfg_ser_w,
  input  logic          cfg_out_off,
  output logic [OW-1:0] word_out,
  output logic          word_vld,
  output logic          drv_en
);
  logic [DW-1:0] coded;
  logic [DW-1:0] scr;
  logic [XW-1:0] ext;
  logic          ext_keep;
  ser_width_e    ser_w;

  assign ser_w    = ser_width_e'(cfg_ser_w);
  assign ext_keep = (ser_w != SER_W12);
  assign ext      = {XW{ovr_pos}};

  adc_fmt_clip_conv #(.DW(DW)) u_conv (
    .smp(smp_in), .ovr_pos(ovr_pos), .ovr_neg(ovr_neg),
    .twos(cfg_twos), .code(coded)
  );

  adc_fmt_scramble #(.DW(DW)) u_scr (
    .en(cfg_scramble), .din(coded), .dout(scr)
  );

  adc_fmt_out_stage #(.DW(DW), .XW(XW)) u_out (
    .clk(clk), .rst(rst), .data(scr), .ext(ext), .ext_keep(ext_keep),
    .tp_en(cfg_tp_en), .tp_val(cfg_tp_val), .off(cfg_out_off),
    .vld_in(smp_vld), .word_out(word_out), .word_vld(word_vld), .drv_en(drv_en)
  );

  // R5: descrambling the scrambler output gives back the coded value
  a_r5_roundtrip: assert property (@(posedge clk) disable iff (rst)
    xor_lsb(scr) == (cfg_scramble ? coded : xor_lsb(coded)));

  // R7: disable clears word, valid and driver enable
  a_r7_off_quiet: assert property (@(posedge clk) disable iff (rst)
    cfg_out_off |=> (word_out == '0 && !word_vld && !drv_en));

  // R7: enabled output always drives
  a_r7_drv_on: assert property (@(posedge clk) disable iff (rst)
    !cfg_out_off |=> drv_en);

  // R4: status bits stay 0 in 12-bit mode
  a_r4_ext_12: assert property (@(posedge clk) disable iff (rst)
    (cfg_ser_w == 2'd0) |=> (word_out[OW-1:DW] == '0));

  // R4: positive overrange sets both status bits in wide modes
  a_r4_ext_pos: assert property (@(posedge clk) disable iff (rst)
    (ovr_pos && !cfg_tp_en && !cfg_out_off && cfg_ser_w != 2'd0)
      |=> (word_out[OW-1:DW] == {XW{1'b1}}));

  // R3: positive overrange clips to the top offset-binary code
  a_r3_clip_top: assert property (@(posedge clk) disable iff (rst)
    (ovr_pos && !cfg_tp_en && !cfg_out_off && !cfg_twos && !cfg_scramble)
      |=> (word_out[DW-1:0] == {DW{1'b1}}));

  // R6: the test pattern reaches the output unchanged in wide modes
  a_r6_tp: assert property (@(posedge clk) disable iff (rst)
    (cfg_tp_en && !cfg_out_off && cfg_ser_w != 2'd0)
      |=> (word_out == $past(cfg_tp_val)));

  // R8: valid follows the input valid by one cycle
  a_r8_vld: assert property (@(posedge clk) disable iff (rst)
    !cfg_out_off |=> (word_vld == $past(smp_vld)));
endmodule

// File: tb/adc_word_fmt_tb.sv
module adc_word_fmt_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] smp_in = '0;
  logic        smp_vld = 1'b0, ovr_pos = 1'b0, ovr_neg = 1'b0;
  logic        cfg_twos = 1'b0, cfg_scramble = 1'b0, cfg_tp_en = 1'b0, cfg_out_off = 1'b0;
  logic [13:0] cfg_tp_val = '0;
  logic [1:0]  cfg_ser_w = 2'd1;
  logic [13:0] word_out;
  logic        word_vld, drv_en;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_word_fmt u_dut (
    .clk(clk), .rst(rst), .smp_in(smp_in), .smp_vld(smp_vld),
    .ovr_pos(ovr_pos), .ovr_neg(ovr_neg), .cfg_twos(cfg_twos),
    .cfg_scramble(cfg_scramble), .cfg_tp_en(cfg_tp_en), .cfg_tp_val(cfg_tp_val),
    .cfg_ser_w(cfg_ser_w), .cfg_out_off(cfg_out_off),
    .word_out(word_out), .word_vld(word_vld), .drv_en(drv_en)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: integer arithmetic on the requirements.
  int exp_data, exp_ext, exp_vld, exp_drv, pre_scr;
  string tag;

  task automatic model();
    int v;
    if (ovr_pos) v = 4095; else if (ovr_neg) v = 0; else v = int'(smp_in);
    if (cfg_twos) v = (v - 2048) & 4095;
    pre_scr = v;
    if (cfg_scramble && (v % 2 == 1)) v = 4095 - v + 1;  // invert bits 11..1, keep bit 0
    exp_data = v;
    exp_ext  = (cfg_ser_w != 0 && ovr_pos) ? 3 : 0;
    if (cfg_tp_en) begin
      exp_data = int'(cfg_tp_val[11:0]);
      exp_ext  = (cfg_ser_w != 0) ? int'(cfg_tp_val[13:12]) : 0;
    end
    exp_vld = smp_vld ? 1 : 0;
    exp_drv = 1;
    if (cfg_out_off) begin exp_data = 0; exp_ext = 0; exp_vld = 0; exp_drv = 0; end
    if (cfg_out_off)               tag = "R7";
    else if (cfg_tp_en)            tag = "R6";
    else if (ovr_pos || ovr_neg)   tag = "R3";
    else if (cfg_scramble)         tag = "R5";
    else if (cfg_twos)             tag = "R2";
    else                           tag = "R1";
  endtask

  // Inputs are already set at a falling edge; one rising edge, then compare.
  task automatic step();
    model();
    @(posedge clk);
    @(negedge clk);
    check({tag, " data"}, int'(word_out[11:0]), exp_data);
    check("R4 status bits", int'(word_out[13:12]), exp_ext);
    check("R8 valid", int'(word_vld), exp_vld);
    check("R7 drv_en", int'(drv_en), exp_drv);
    if (cfg_scramble && !cfg_tp_en && !cfg_out_off)
      check("R5 decode", int'(adc_fmt_pkg::xor_lsb(word_out[11:0])), pre_scr);
  endtask

  task automatic set(input logic [11:0] s, input logic p, input logic n,
                     input logic tw, input logic sc, input logic tp,
                     input logic [1:0] w, input logic off);
    smp_in = s; ovr_pos = p; ovr_neg = n; cfg_twos = tw; cfg_scramble = sc;
    cfg_tp_en = tp; cfg_ser_w = w; cfg_out_off = off; smp_vld = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R9: reset state
    check("R9 word", int'(word_out), 0);
    check("R9 valid", int'(word_vld), 0);
    check("R9 drv_en", int'(drv_en), 0);
    rst = 1'b0;

    // R1 offset binary extremes
    set(12'h800, 0, 0, 0, 0, 0, 2'd1, 0); step();
    set(12'hFFF, 0, 0, 0, 0, 0, 2'd1, 0); step();
    set(12'h000, 0, 0, 0, 0, 0, 2'd1, 0); step();
    set(12'h123, 0, 0, 0, 0, 0, 2'd2, 0); step();
    // R2 two's complement
    set(12'h800, 0, 0, 1, 0, 0, 2'd1, 0); step();
    set(12'hFFF, 0, 0, 1, 0, 0, 2'd1, 0); step();
    set(12'h000, 0, 0, 1, 0, 0, 2'd1, 0); step();
    // R3 clipping, both codings, both widths; R4 status bits
    set(12'h555, 1, 0, 0, 0, 0, 2'd1, 0); step();
    set(12'h555, 1, 0, 1, 0, 0, 2'd2, 0); step();
    set(12'h555, 0, 1, 0, 0, 0, 2'd1, 0); step();
    set(12'h555, 0, 1, 1, 0, 0, 2'd3, 0); step();
    set(12'h555, 1, 1, 0, 0, 0, 2'd1, 0); step();
    set(12'h555, 1, 0, 0, 0, 0, 2'd0, 0); step();
    // R5 scrambler, odd and even samples
    set(12'h0A5, 0, 0, 0, 1, 0, 2'd1, 0); step();
    set(12'h0A4, 0, 0, 0, 1, 0, 2'd1, 0); step();
    set(12'h801, 0, 0, 1, 1, 0, 2'd1, 0); step();
    // R6 test pattern overrides everything
    cfg_tp_val = 14'h2ABC;
    set(12'h001, 1, 0, 1, 1, 1, 2'd1, 0); step();
    set(12'h001, 1, 0, 1, 1, 1, 2'd0, 0); step();
    cfg_tp_val = 14'h3001;
    set(12'h7FF, 0, 0, 0, 1, 1, 2'd2, 0); step();
    // R7 disable
    set(12'hFFF, 1, 0, 0, 0, 0, 2'd1, 1); step();
    set(12'hFFF, 1, 0, 0, 0, 1, 2'd1, 1); step();
    // R8 valid low
    set(12'h321, 0, 0, 0, 0, 0, 2'd1, 0); smp_vld = 1'b0; step();

    // Mixed random patterns
    for (int i = 0; i < 400; i++) begin
      smp_in       = 12'($urandom);
      smp_vld      = 1'($urandom);
      ovr_pos      = ($urandom % 6) == 0;
      ovr_neg      = ($urandom % 6) == 0;
      cfg_twos     = 1'($urandom);
      cfg_scramble = 1'($urandom);
      cfg_tp_en    = ($urandom % 5) == 0;
      cfg_tp_val   = 14'($urandom);
      cfg_ser_w    = 2'($urandom);
      cfg_out_off  = ($urandom % 8) == 0;
      step();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule